// File: doc/BRIEF.md
# Dual-Core Boot Power-Up Controller

This block decides which power domains of a two-processor subsystem ask for power when the subsystem leaves reset. It also decides when each processor may begin to boot. There are six shared domains: one system domain, one crypto domain and four SRAM banks. These are always requested once cold reset is released. Each of the two core domains is requested automatically only if that core's hold bit is clear. The hold bits live in a two-bit register that is written through a plain synchronous port.

A hold bit gates automatic power-up only while its core has not yet powered up since the last cold reset. Once the core's acknowledge has been seen, the bit no longer stops a later power-up. The same applies once a power-down event has been seen. After that point the bit only holds the core out of boot. A warm reset powers both cores up without looking at the hold bits. A debugger request powers a core up even when its hold bit is set, but the boot hold still applies while the bit is set.

Power switching, the processors and the boot-address logic lie outside the block. They reach it only through the per-core acknowledge inputs. All pins are plain level control signals. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `boot_power_ctrl`

## Requirements
- R1: While `cold_rst_n` is low at a rising edge, every request output and both `boot_go` bits are low after that edge.
- R2: At the first rising edge with `cold_rst_n` high, `sys_pwr_req`, `crypto_pwr_req` and all four `sram_pwr_req` bits go high. They stay high until the next cold reset.
- R3: At the first rising edge after cold reset is released, `core_pwr_req[i]` goes high if and only if hold bit i is 0.
- R4: Cold reset loads hold bit 0 from parameter `CORE0_HOLD_INIT` and hold bit 1 from `CORE1_HOLD_INIT`.
- R5: A rising edge with `hold_we` high loads `hold_wdata` into the hold register, with bit i belonging to core i. The new value applies from the next cycle. Warm reset leaves the register unchanged.
- R6: After each edge outside reset, `boot_go[i]` equals the value that `core_pwr_req[i] & core_pwr_ack[i] & ~hold[i]` had before that edge. It is 0 after any edge at which either reset is low.
- R7: An edge with `warm_rst_n` low sets both `core_pwr_req` bits to 1 regardless of the hold bits. The shared domain requests are not changed.
- R8: An edge with `core_pwr_down[i]` high, outside any reset, clears `core_pwr_req[i]`. This takes priority over a debugger request.
- R9: An edge with `dbg_pwr_req[i]` high and no power-down or reset sets `core_pwr_req[i]`, even if hold bit i is 1.
- R10: Automatic power-up of core i applies only while its first-power-up state is set. Cold reset sets that state. It is cleared once `core_pwr_ack[i]` or `core_pwr_down[i]` has been seen high at an edge. While the state is set and the hold bit is 0, the request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Synchronous cold reset, active low |
| warm_rst_n | input | 1 | Synchronous warm reset, active low |
| hold_we | input | 1 | Hold register write enable |
| hold_wdata | input | 2 | Hold register write data, bit i for core i |
| dbg_pwr_req | input | 2 | Debugger power-up request per core |
| core_pwr_down | input | 2 | Power-down event per core |
| core_pwr_ack | input | 2 | Power-up acknowledge per core |
| core_pwr_req | output | 2 | Core domain power-up requests |
| sys_pwr_req | output | 1 | System domain power-up request |
| crypto_pwr_req | output | 1 | Crypto domain power-up request |
| sram_pwr_req | output | 4 | SRAM bank power-up requests |
| boot_go | output | 2 | Boot release per core |

## Verification
The bench builds the block with `CORE0_HOLD_INIT = 0` and `CORE1_HOLD_INIT = 1`. After one cold reset, the two cores therefore take opposite paths: core 0 powers up and boots by itself, and core 1 stays dark. This makes it possible to check the gated path, the debugger override and the boot hold on core 1 in the same run, while core 0 exercises power-down and the end of gating. A second cold reset reloads the mixed defaults. With the acknowledge held off, clearing core 1's hold bit before its first power-up then shows the gating lifting.

// File: rtl/boot_pwr_pkg.sv
package boot_pwr_pkg;
  localparam int unsigned NUM_CORES = 2;
  localparam int unsigned NUM_SRAM  = 4;

  typedef enum logic [2:0] {
    ACT_KEEP,
    ACT_COLD,
    ACT_WARM,
    ACT_DOWN,
    ACT_DBG,
    ACT_AUTO
  } req_act_e;
endpackage

// File: rtl/hold_reg_bank.sv
module hold_reg_bank #(
  parameter int unsigned     N    = 2,
  parameter logic [N-1:0]    INIT = '0
) (
  input  logic         clk,
  input  logic         cold_rst_n,
  input  logic         we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] hold
);
  logic [N-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!cold_rst_n)  hold_q <= INIT;
    else if (we)      hold_q <= wdata;
  end

  assign hold = hold_q;
endmodule

// File: rtl/shared_domain_ctrl.sv
module shared_domain_ctrl #(
  parameter int unsigned NSRAM = 4
) (
  input  logic             clk,
  input  logic             cold_rst_n,
  output logic             sys_req,
  output logic             crypto_req,
  output logic [NSRAM-1:0] sram_req
);
  logic on_q;

  always_ff @(posedge clk) begin
    if (!cold_rst_n) on_q <= 1'b0;
    else             on_q <= 1'b1;
  end

  assign sys_req    = on_q;
  assign crypto_req = on_q;
  assign sram_req   = {NSRAM{on_q}};
endmodule

// File: rtl/core_pwr_slice.sv
module core_pwr_slice
  import boot_pwr_pkg::*;
(
  input  logic clk,
  input  logic cold_rst_n,
  input  logic warm_rst_n,
  input  logic hold,
  input  logic dbg_req,
  input  logic pwr_down,
  input  logic pwr_ack,
  output logic pwr_req,
  output logic boot_go
);
  logic     req_q, first_q, boot_q;
  req_act_e act;

  // priority: cold > warm > power-down > debugger > automatic
  always_comb begin
    if (!cold_rst_n)             act = ACT_COLD;
    else if (!warm_rst_n)        act = ACT_WARM;
    else if (pwr_down)           act = ACT_DOWN;
    else if (dbg_req)            act = ACT_DBG;
    else if (first_q && !hold)   act = ACT_AUTO;
    else                         act = ACT_KEEP;
  end

  always_ff @(posedge clk) begin
    case (act)
      ACT_COLD: req_q <= 1'b0;
      ACT_DOWN: req_q <= 1'b0;
      ACT_WARM, ACT_DBG, ACT_AUTO: req_q <= 1'b1;
      default:  req_q <= req_q;
    endcase
  end

  // first-power-up state: armed by cold reset, retired by ack or power-down
  always_ff @(posedge clk) begin
    if (!cold_rst_n)            first_q <= 1'b1;
    else if (pwr_ack || pwr_down) first_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!cold_rst_n || !warm_rst_n) boot_q <= 1'b0;
    else                            boot_q <= req_q && pwr_ack && !hold;
  end

  assign pwr_req = req_q;
  assign boot_go = boot_q;
endmodule

// File: rtl/boot_power_ctrl.sv
module boot_power_ctrl
  import boot_pwr_pkg::*;
#(
  parameter bit CORE0_HOLD_INIT = 1'b0,
  parameter bit CORE1_HOLD_INIT = 1'b1
) (
  input  logic                 clk,
  input  logic                 cold_rst_n,
  input  logic                 warm_rst_n,
  input  logic                 hold_we,
  input  logic [NUM_CORES-1:0] hold_wdata,
  input  logic [NUM_CORES-1:0] dbg_pwr_req,
  input  logic [NUM_CORES-1:0] core_pwr_down,
  input  logic [NUM_CORES-1:0] core_pwr_ack,
  output logic [NUM_CORES-1:0] core_pwr_req,
  output logic                 sys_pwr_req,
  output logic                 crypto_pwr_req,
  output logic [NUM_SRAM-1:0]  sram_pwr_req,
  output logic [NUM_CORES-1:0] boot_go
);
  localparam logic [NUM_CORES-1:0] HOLD_INIT = {CORE1_HOLD_INIT, CORE0_HOLD_INIT};

  logic [NUM_CORES-1:0] hold;

  hold_reg_bank #(.N(NUM_CORES), .INIT(HOLD_INIT)) u_hold (
    .clk(clk), .cold_rst_n(cold_rst_n), .we(hold_we), .wdata(hold_wdata), .hold(hold)
  );

  shared_domain_ctrl #(.NSRAM(NUM_SRAM)) u_shared (
    .clk(clk), .cold_rst_n(cold_rst_n), .sys_req(sys_pwr_req),
    .crypto_req(crypto_pwr_req), .sram_req(sram_pwr_req)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    core_pwr_slice u_slice (
      .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
      .hold(hold[i]), .dbg_req(dbg_pwr_req[i]), .pwr_down(core_pwr_down[i]),
      .pwr_ack(core_pwr_ack[i]), .pwr_req(core_pwr_req[i]), .boot_go(boot_go[i])
    );
  end
endmodule

// File: rtl/boot_power_ctrl_chk.sv
module boot_power_ctrl_chk (
  input logic       clk,
  input logic       cold_rst_n,
  input logic       warm_rst_n,
  input logic [1:0] dbg_pwr_req,
  input logic [1:0] core_pwr_down,
  input logic [1:0] core_pwr_ack,
  input logic [1:0] core_pwr_req,
  input logic       sys_pwr_req,
  input logic       crypto_pwr_req,
  input logic [3:0] sram_pwr_req,
  input logic [1:0] boot_go
);
  assert_cold_clears_R1: assert property (@(posedge clk)
    !cold_rst_n |=> (core_pwr_req == 2'b00 && boot_go == 2'b00 &&
                     !sys_pwr_req && !crypto_pwr_req && sram_pwr_req == 4'h0));

  assert_shared_on_R2: assert property (@(posedge clk) disable iff (!cold_rst_n)
    cold_rst_n |=> (sys_pwr_req && crypto_pwr_req && sram_pwr_req == 4'hF));

  assert_warm_powers_R7: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !warm_rst_n |=> (core_pwr_req == 2'b11 && boot_go == 2'b00));

  for (genvar i = 0; i < 2; i++) begin : g_chk
    assert_down_drops_R8: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (warm_rst_n && core_pwr_down[i]) |=> !core_pwr_req[i]);

    assert_dbg_raises_R9: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (warm_rst_n && !core_pwr_down[i] && dbg_pwr_req[i]) |=> core_pwr_req[i]);

    assert_boot_needs_ack_R6: assert property (@(posedge clk) disable iff (!cold_rst_n)
      boot_go[i] |-> ($past(core_pwr_ack[i]) && $past(core_pwr_req[i]) && $past(warm_rst_n)));
  end
endmodule

bind boot_power_ctrl boot_power_ctrl_chk u_chk (
  .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
  .dbg_pwr_req(dbg_pwr_req), .core_pwr_down(core_pwr_down), .core_pwr_ack(core_pwr_ack),
  .core_pwr_req(core_pwr_req), .sys_pwr_req(sys_pwr_req), .crypto_pwr_req(crypto_pwr_req),
  .sram_pwr_req(sram_pwr_req), .boot_go(boot_go)
);

// File: tb/boot_power_ctrl_bench.sv
`timescale 1ns/1ps
module boot_power_ctrl_bench;
  localparam bit INIT0 = 1'b0;
  localparam bit INIT1 = 1'b1;

  logic       clk = 1'b0;
  logic       cold_rst_n = 1'b0, warm_rst_n = 1'b1, hold_we = 1'b0;
  logic [1:0] hold_wdata = '0, dbg_pwr_req = '0, core_pwr_down = '0, core_pwr_ack = '0;
  logic [1:0] core_pwr_req, boot_go;
  logic       sys_pwr_req, crypto_pwr_req;
  logic [3:0] sram_pwr_req;

  always #5 clk = ~clk;

  boot_power_ctrl #(.CORE0_HOLD_INIT(INIT0), .CORE1_HOLD_INIT(INIT1)) u_boot_power_ctrl (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n), .hold_we(hold_we),
    .hold_wdata(hold_wdata), .dbg_pwr_req(dbg_pwr_req), .core_pwr_down(core_pwr_down),
    .core_pwr_ack(core_pwr_ack), .core_pwr_req(core_pwr_req), .sys_pwr_req(sys_pwr_req),
    .crypto_pwr_req(crypto_pwr_req), .sram_pwr_req(sram_pwr_req), .boot_go(boot_go)
  );

  // behavioural reference
  int    m_hold[2], m_first[2], m_req[2], m_boot[2];
  int    m_shared = 0;
  int    checks = 0, failures = 0;
  bit    started = 0, ack_auto = 1;
  string tag = "R1 cold reset";

  always @(posedge clk) begin
    int nreq[2], nboot[2], nfirst[2];
    started <= 1;
    if (!cold_rst_n) begin
      m_hold[0] = INIT0; m_hold[1] = INIT1; m_shared = 0;
      for (int i = 0; i < 2; i++) begin m_first[i] = 1; m_req[i] = 0; m_boot[i] = 0; end
    end else begin
      m_shared = 1;
      for (int i = 0; i < 2; i++) begin
        if (!warm_rst_n)                       nreq[i] = 1;
        else if (core_pwr_down[i])             nreq[i] = 0;
        else if (dbg_pwr_req[i])               nreq[i] = 1;
        else if (m_first[i] && m_hold[i] == 0) nreq[i] = 1;
        else                                   nreq[i] = m_req[i];
        nfirst[i] = (core_pwr_ack[i] || core_pwr_down[i]) ? 0 : m_first[i];
        nboot[i]  = (warm_rst_n && m_req[i] && core_pwr_ack[i] && m_hold[i] == 0) ? 1 : 0;
      end
      for (int i = 0; i < 2; i++) begin
        m_req[i] = nreq[i]; m_first[i] = nfirst[i]; m_boot[i] = nboot[i];
      end
      if (hold_we) begin m_hold[0] = hold_wdata[0]; m_hold[1] = hold_wdata[1]; end
    end
  end

  task automatic cmp(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s [%s] actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      cmp("core_pwr_req", {6'd0, core_pwr_req}, {6'd0, m_req[1][0], m_req[0][0]});
      cmp("boot_go", {6'd0, boot_go}, {6'd0, m_boot[1][0], m_boot[0][0]});
      cmp("shared", {2'd0, sys_pwr_req, crypto_pwr_req, sram_pwr_req},
          {2'd0, {6{m_shared[0]}}});
    end
    if (ack_auto) core_pwr_ack = core_pwr_req;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_hold(logic [1:0] v);
    hold_we = 1'b1; hold_wdata = v; cyc(1); hold_we = 1'b0;
  endtask

  initial begin
    fork
      begin
        cyc(4);
        tag = "R2 R3 R4 cold start, core0 auto up, core1 held";
        cold_rst_n = 1'b1; cyc(6);
        tag = "R6 boot release follows ack and clear hold";
        cyc(2);
        tag = "R5 hold write delays core0 boot";
        wr_hold(2'b11); cyc(3);
        wr_hold(2'b10); cyc(3);
        tag = "R9 debugger powers held core1, boot still held";
        dbg_pwr_req = 2'b10; cyc(1); dbg_pwr_req = 2'b00; cyc(4);
        tag = "R6 clearing hold releases core1 boot";
        wr_hold(2'b00); cyc(3);
        tag = "R8 power-down beats debugger on core0";
        core_pwr_down = 2'b01; dbg_pwr_req = 2'b01; cyc(1);
        core_pwr_down = 2'b00; dbg_pwr_req = 2'b00; cyc(4);
        tag = "R10 no auto re-power after first power-up";
        wr_hold(2'b01); wr_hold(2'b00); cyc(4);
        tag = "R9 debugger re-powers core0";
        dbg_pwr_req = 2'b01; cyc(1); dbg_pwr_req = 2'b00; cyc(4);
        tag = "R7 warm reset re-powers both ignoring hold";
        core_pwr_down = 2'b11; cyc(1); core_pwr_down = 2'b00; cyc(2);
        wr_hold(2'b11);
        warm_rst_n = 1'b0; cyc(2); warm_rst_n = 1'b1; cyc(4);
        tag = "R5 hold survives warm reset, clear releases boot";
        wr_hold(2'b00); cyc(4);
        tag = "R1 second cold reset";
        ack_auto = 0; core_pwr_ack = 2'b00;
        cold_rst_n = 1'b0; cyc(3);
        tag = "R3 R4 defaults reloaded, no ack";
        cold_rst_n = 1'b1; cyc(4);
        tag = "R10 clearing hold before first power-up raises core1";
        wr_hold(2'b00); cyc(3);
        tag = "R10 power-down retires first-power-up state";
        wr_hold(2'b10);
        core_pwr_down = 2'b01; cyc(1); core_pwr_down = 2'b00;
        wr_hold(2'b00); cyc(4);
      end
      begin
        cyc(5000);
        failures++;
        $display("FAIL watchdog expired at %0t", $time);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule